// File: doc/BRIEF.md
# Integer Execute Unit with Signed-Overflow Trap

This block is the integer execute stage of a load-store RISC core. It is purely combinational: given an operation code, two operands and a constant shift amount, it returns a result word in the same cycle. It also returns an overflow-trap flag and a write-suppress flag. The core's register file and exception logic use the write-suppress flag to keep the faulting result out of the destination register. Immediate forms such as add-immediate are served by the same codes, with the caller placing the already-extended immediate on operand B.

The unit covers:
- signed and unsigned addition and subtraction;
- the four bitwise functions;
- left, right-logical and right-arithmetic shifts, each by a constant or by a register amount;
- signed and unsigned set-on-less-than;
- upper-half immediate load.

Only the signed add and subtract codes can trap. Every other code, including all unassigned code values, leaves both flags low. The block has no handshake: the result and flags are valid whenever the inputs are stable.

Top module: `int_exec_alu`

## Requirements

Opcode encoding on `op_i` (decimal):
- 0 ADD, 1 ADDU, 2 SUB, 3 SUBU
- 4 AND, 5 OR, 6 XOR, 7 NOR
- 8 SLL, 9 SRL, 10 SRA
- 11 SLLV, 12 SRLV, 13 SRAV
- 14 SLT, 15 SLTU, 16 LUI
- 17 to 31 are unassigned.

Shifts move `opa_i`.

- R1: ADD gives `opa_i + opb_i` modulo 2^32 and SUB gives `opa_i - opb_i` modulo 2^32. For both, `ovf_trap_o` is 1 exactly when the true two's-complement result lies outside -2^31 to 2^31-1.
- R2: ADDU and SUBU give the same result bits as ADD and SUB, and `ovf_trap_o` is always 0 for them.
- R3: `wr_suppress_o` equals `ovf_trap_o` for every code. When the trap is raised, `result_o` still carries the wrapped sum or difference.
- R4: AND, OR and XOR give the bitwise function of the operands. NOR gives the inverse of their OR.
- R5: SLL, SRL and SRA shift `opa_i` by `shamt_i`. SLL and SRL fill the vacated bits with zeros; SRA fills them with copies of bit 31 of `opa_i`.
- R6: SLLV, SRLV and SRAV shift `opa_i` by `opb_i[4:0]`, using the same fill rules as R5. Bits 31:5 of `opb_i` have no effect on the result.
- R7: SLT gives 1 when `opa_i` is below `opb_i` as two's-complement numbers, and 0 otherwise.
- R8: SLTU gives 1 when `opa_i` is below `opb_i` as unsigned numbers, and 0 otherwise.
- R9: LUI places `opb_i[15:0]` in result bits 31:16 and zeros bits 15:0.
- R10: Codes 17 to 31 give a zero result. Every code other than ADD and SUB holds `ovf_trap_o` at 0.

## Ports

| Port | Direction | Width | Description |
|---|---|---|---|
| op_i | input | 5 | Operation code, encoded as in the requirements |
| opa_i | input | 32 | Operand A; the shifted value for shift codes |
| opb_i | input | 32 | Operand B; extended immediate for immediate forms; low 5 bits give the variable shift amount |
| shamt_i | input | 5 | Constant shift amount |
| result_o | output | 32 | Result word |
| ovf_trap_o | output | 1 | Signed overflow on ADD or SUB |
| wr_suppress_o | output | 1 | Block the destination write this cycle |

## Verification

The bench drives these trap boundaries:
- the largest positive value plus one, and the most negative value minus one;
- zero minus the most negative value, and operands of opposite sign on SUB.

A unit that used the add rule for subtraction, or that checked only the carry, would trap on the wrong cases. The same operands are applied to ADDU and SUBU to catch a trap leaking into the unsigned forms.

For shifts, the bench covers:
- a set sign bit shifted by 31;
- a shift by 0;
- variable amounts carried in an operand B whose upper bits are set.

A shifter with the wrong fill, or one that read more than five amount bits, would give a wrong word. Set-less-than is driven with operands of mixed sign, where the signed and unsigned answers differ, so swapped comparators show up.

// File: rtl/alu_pkg.sv
package alu_pkg;

  typedef enum logic [4:0] {
    OP_ADD  = 5'd0,
    OP_ADDU = 5'd1,
    OP_SUB  = 5'd2,
    OP_SUBU = 5'd3,
    OP_AND  = 5'd4,
    OP_OR   = 5'd5,
    OP_XOR  = 5'd6,
    OP_NOR  = 5'd7,
    OP_SLL  = 5'd8,
    OP_SRL  = 5'd9,
    OP_SRA  = 5'd10,
    OP_SLLV = 5'd11,
    OP_SRLV = 5'd12,
    OP_SRAV = 5'd13,
    OP_SLT  = 5'd14,
    OP_SLTU = 5'd15,
    OP_LUI  = 5'd16
  } alu_op_e;

  typedef enum logic [2:0] {
    SEL_NONE,
    SEL_ARITH,
    SEL_LOGIC,
    SEL_SHIFT,
    SEL_CMP,
    SEL_UPPER
  } res_sel_e;

  typedef enum logic [1:0] {
    LF_AND,
    LF_OR,
    LF_XOR,
    LF_NOR
  } logic_fn_e;

  typedef struct packed {
    res_sel_e  sel;
    logic      sub;
    logic      trap_en;
    logic_fn_e lfn;
    logic      sh_left;
    logic      sh_arith;
    logic      sh_var;
    logic      cmp_uns;
  } alu_ctrl_t;

endpackage

// File: rtl/alu_addsub.sv
module alu_addsub #(
  parameter int WIDTH = 32
) (
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  input  logic             sub_i,
  output logic [WIDTH-1:0] sum_o,
  output logic             ovf_o,
  output logic             lt_s_o,
  output logic             lt_u_o
);
  localparam int MSB = WIDTH - 1;

  logic [WIDTH-1:0] b_eff;
  logic [WIDTH:0]   full;

  always_comb begin
    b_eff  = sub_i ? ~b_i : b_i;
    full   = {1'b0, a_i} + {1'b0, b_eff} + {{WIDTH{1'b0}}, sub_i};
    sum_o  = full[MSB:0];
    if (sub_i) ovf_o = (a_i[MSB] ^ b_i[MSB]) & (a_i[MSB] ^ sum_o[MSB]);
    else       ovf_o = ~(a_i[MSB] ^ b_i[MSB]) & (a_i[MSB] ^ sum_o[MSB]);
    lt_s_o = (a_i[MSB] != b_i[MSB]) ? a_i[MSB] : sum_o[MSB];
    lt_u_o = ~full[WIDTH];
  end

  always_comb begin
    if (sub_i && (a_i == b_i))
      assert_eq_not_less_R7: assert (!lt_s_o && !lt_u_o && !ovf_o);
  end

endmodule

// File: rtl/alu_logic.sv
module alu_logic #(
  parameter int WIDTH = 32
) (
  input  logic [WIDTH-1:0]   a_i,
  input  logic [WIDTH-1:0]   b_i,
  input  alu_pkg::logic_fn_e fn_i,
  output logic [WIDTH-1:0]   y_o
);
  import alu_pkg::*;

  always_comb begin
    unique case (fn_i)
      LF_AND:  y_o = a_i & b_i;
      LF_OR:   y_o = a_i | b_i;
      LF_XOR:  y_o = a_i ^ b_i;
      default: y_o = ~(a_i | b_i);
    endcase
  end

endmodule

// File: rtl/alu_shifter.sv
module alu_shifter #(
  parameter int WIDTH = 32,
  localparam int SHW = $clog2(WIDTH)
) (
  input  logic [WIDTH-1:0] val_i,
  input  logic [SHW-1:0]   amt_i,
  input  logic             left_i,
  input  logic             arith_i,
  output logic [WIDTH-1:0] y_o
);
  logic             fill;
  logic [WIDTH-1:0] rev_in;
  logic [WIDTH-1:0] rev_out;
  logic [WIDTH-1:0] stg [0:SHW];

  assign fill = arith_i & ~left_i & val_i[WIDTH-1];

  for (genvar i = 0; i < WIDTH; i++) begin : g_rev
    assign rev_in[i]  = val_i[WIDTH-1-i];
    assign rev_out[i] = stg[SHW][WIDTH-1-i];
  end

  assign stg[0] = left_i ? rev_in : val_i;

  for (genvar k = 0; k < SHW; k++) begin : g_stage
    localparam int STEP = 1 << k;
    assign stg[k+1] = amt_i[k] ? {{STEP{fill}}, stg[k][WIDTH-1:STEP]} : stg[k];
  end

  assign y_o = left_i ? rev_out : stg[SHW];

  always_comb begin
    if (arith_i && !left_i)
      assert_sra_keeps_sign_R5: assert (y_o[WIDTH-1] == val_i[WIDTH-1]);
    if (amt_i == '0)
      assert_zero_shift_R6: assert (y_o == val_i);
  end

endmodule

// File: rtl/int_exec_alu.sv
module int_exec_alu #(
  parameter int WIDTH = 32
) (
  input  logic [4:0]               op_i,
  input  logic [WIDTH-1:0]         opa_i,
  input  logic [WIDTH-1:0]         opb_i,
  input  logic [$clog2(WIDTH)-1:0] shamt_i,
  output logic [WIDTH-1:0]         result_o,
  output logic                     ovf_trap_o,
  output logic                     wr_suppress_o
);
  import alu_pkg::*;

  localparam int SHW  = $clog2(WIDTH);
  localparam int HALF = WIDTH / 2;

  alu_ctrl_t        ctl;
  logic [WIDTH-1:0] sum, lres, sres;
  logic             ovf, lt_s, lt_u, cmp_bit;
  logic [SHW-1:0]   amt;

  always_comb begin
    ctl = '{sel: SEL_NONE, sub: 1'b0, trap_en: 1'b0, lfn: LF_AND,
            sh_left: 1'b0, sh_arith: 1'b0, sh_var: 1'b0, cmp_uns: 1'b0};
    case (op_i)
      OP_ADD:  begin ctl.sel = SEL_ARITH; ctl.trap_en = 1'b1; end
      OP_ADDU: ctl.sel = SEL_ARITH;
      OP_SUB:  begin ctl.sel = SEL_ARITH; ctl.sub = 1'b1; ctl.trap_en = 1'b1; end
      OP_SUBU: begin ctl.sel = SEL_ARITH; ctl.sub = 1'b1; end
      OP_AND:  begin ctl.sel = SEL_LOGIC; ctl.lfn = LF_AND; end
      OP_OR:   begin ctl.sel = SEL_LOGIC; ctl.lfn = LF_OR;  end
      OP_XOR:  begin ctl.sel = SEL_LOGIC; ctl.lfn = LF_XOR; end
      OP_NOR:  begin ctl.sel = SEL_LOGIC; ctl.lfn = LF_NOR; end
      OP_SLL:  begin ctl.sel = SEL_SHIFT; ctl.sh_left = 1'b1; end
      OP_SRL:  ctl.sel = SEL_SHIFT;
      OP_SRA:  begin ctl.sel = SEL_SHIFT; ctl.sh_arith = 1'b1; end
      OP_SLLV: begin ctl.sel = SEL_SHIFT; ctl.sh_left = 1'b1; ctl.sh_var = 1'b1; end
      OP_SRLV: begin ctl.sel = SEL_SHIFT; ctl.sh_var = 1'b1; end
      OP_SRAV: begin ctl.sel = SEL_SHIFT; ctl.sh_arith = 1'b1; ctl.sh_var = 1'b1; end
      OP_SLT:  begin ctl.sel = SEL_CMP; ctl.sub = 1'b1; end
      OP_SLTU: begin ctl.sel = SEL_CMP; ctl.sub = 1'b1; ctl.cmp_uns = 1'b1; end
      OP_LUI:  ctl.sel = SEL_UPPER;
      default: ctl.sel = SEL_NONE;
    endcase
  end

  alu_addsub #(.WIDTH(WIDTH)) u_addsub (
    .a_i    (opa_i),
    .b_i    (opb_i),
    .sub_i  (ctl.sub),
    .sum_o  (sum),
    .ovf_o  (ovf),
    .lt_s_o (lt_s),
    .lt_u_o (lt_u)
  );

  alu_logic #(.WIDTH(WIDTH)) u_logic (
    .a_i  (opa_i),
    .b_i  (opb_i),
    .fn_i (ctl.lfn),
    .y_o  (lres)
  );

  assign amt = ctl.sh_var ? opb_i[SHW-1:0] : shamt_i;

  alu_shifter #(.WIDTH(WIDTH)) u_shift (
    .val_i   (opa_i),
    .amt_i   (amt),
    .left_i  (ctl.sh_left),
    .arith_i (ctl.sh_arith),
    .y_o     (sres)
  );

  assign cmp_bit = ctl.cmp_uns ? lt_u : lt_s;

  always_comb begin
    unique case (ctl.sel)
      SEL_ARITH: result_o = sum;
      SEL_LOGIC: result_o = lres;
      SEL_SHIFT: result_o = sres;
      SEL_CMP:   result_o = {{(WIDTH-1){1'b0}}, cmp_bit};
      SEL_UPPER: result_o = {opb_i[HALF-1:0], {HALF{1'b0}}};
      default:   result_o = '0;
    endcase
  end

  assign ovf_trap_o    = ctl.trap_en & ovf;
  assign wr_suppress_o = ovf_trap_o;

  always_comb begin
    if (op_i == OP_ADDU || op_i == OP_SUBU)
      assert_unsigned_no_trap_R2: assert (!ovf_trap_o);
    if (ovf_trap_o)
      assert_trap_only_signed_R10: assert (op_i == OP_ADD || op_i == OP_SUB);
    if (op_i == OP_LUI)
      assert_upper_low_zero_R9: assert (result_o[HALF-1:0] == '0);
    if (op_i == OP_NOR)
      assert_nor_disjoint_R4: assert ((result_o & (opa_i | opb_i)) == '0);
    if (op_i == OP_SLT || op_i == OP_SLTU)
      assert_cmp_single_bit_R7: assert (result_o[WIDTH-1:1] == '0);
  end

endmodule

// File: tb/test_int_exec_alu.sv
module test_int_exec_alu;

  logic        clk = 1'b0;
  logic [4:0]  op;
  logic [31:0] a, b;
  logic [4:0]  sh;
  logic [31:0] res;
  logic        trap, supp;
  int          vectors = 0;
  int          miscompares = 0;

  always #2 clk = ~clk;

  int_exec_alu #(.WIDTH(32)) i_int_exec_alu (
    .op_i          (op),
    .opa_i         (a),
    .opb_i         (b),
    .shamt_i       (sh),
    .result_o      (res),
    .ovf_trap_o    (trap),
    .wr_suppress_o (supp)
  );

  function automatic string tag_of(input logic [4:0] o);
    case (o)
      5'd0, 5'd2:                return "R1";
      5'd1, 5'd3:                return "R2";
      5'd4, 5'd5, 5'd6, 5'd7:    return "R4";
      5'd8, 5'd9, 5'd10:         return "R5";
      5'd11, 5'd12, 5'd13:       return "R6";
      5'd14:                     return "R7";
      5'd15:                     return "R8";
      5'd16:                     return "R9";
      default:                   return "R10";
    endcase
  endfunction

  function automatic logic [32:0] ref_model(input logic [4:0] o, input logic [31:0] x,
                                            input logic [31:0] y, input logic [4:0] s);
    longint      t;
    logic [31:0] r;
    logic        ov;
    ov = 1'b0;
    r  = 32'd0;
    case (o)
      5'd0, 5'd1: begin
        t  = longint'($signed(x)) + longint'($signed(y));
        r  = t[31:0];
        ov = (o == 5'd0) && ((t > 64'sd2147483647) || (t < -64'sd2147483648));
      end
      5'd2, 5'd3: begin
        t  = longint'($signed(x)) - longint'($signed(y));
        r  = t[31:0];
        ov = (o == 5'd2) && ((t > 64'sd2147483647) || (t < -64'sd2147483648));
      end
      5'd4:  r = x & y;
      5'd5:  r = x | y;
      5'd6:  r = x ^ y;
      5'd7:  r = ~(x | y);
      5'd8:  r = x << s;
      5'd9:  r = x >> s;
      5'd10: r = $unsigned($signed(x) >>> s);
      5'd11: r = x << (y % 32);
      5'd12: r = x >> (y % 32);
      5'd13: r = $unsigned($signed(x) >>> (y % 32));
      5'd14: r = ($signed(x) < $signed(y)) ? 32'd1 : 32'd0;
      5'd15: r = (x < y) ? 32'd1 : 32'd0;
      5'd16: r = {y[15:0], 16'h0000};
      default: r = 32'd0;
    endcase
    return {ov, r};
  endfunction

  task automatic apply(input logic [4:0] o, input logic [31:0] x, input logic [31:0] y,
                       input logic [4:0] s);
    logic [32:0] exp;
    @(posedge clk);
    op = o; a = x; b = y; sh = s;
    exp = ref_model(o, x, y, s);
    @(negedge clk);
    vectors++;
    if (res !== exp[31:0] || trap !== exp[32]) begin
      miscompares++;
      $display("FAIL %s op=%0d a=%h b=%h sh=%0d: got res=%h trap=%b, expected res=%h trap=%b",
               tag_of(o), o, x, y, s, res, trap, exp[31:0], exp[32]);
    end
    if (supp !== exp[32]) begin
      miscompares++;
      $display("FAIL R3 op=%0d: got wr_suppress=%b, expected %b", o, supp, exp[32]);
    end
  endtask

  initial begin
    repeat (60000) @(posedge clk);
    miscompares++;
    $display("FAIL watchdog: got no end of run, expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    op = 5'd0; a = 32'd0; b = 32'd0; sh = 5'd0;
    @(negedge clk);
    vectors++;
    if (res !== 32'd0 || trap !== 1'b0 || supp !== 1'b0) begin
      miscompares++;
      $display("FAIL R3 idle: got res=%h trap=%b supp=%b, expected 0 0 0", res, trap, supp);
    end
    // R1: overflow boundaries
    apply(5'd0, 32'h7fffffff, 32'h00000001, 5'd0);
    apply(5'd0, 32'h80000000, 32'hffffffff, 5'd0);
    apply(5'd0, 32'hffffffff, 32'h00000001, 5'd0);
    apply(5'd0, 32'h7ffffffe, 32'h00000001, 5'd0);
    apply(5'd2, 32'h80000000, 32'h00000001, 5'd0);
    apply(5'd2, 32'h7fffffff, 32'hffffffff, 5'd0);
    apply(5'd2, 32'h00000000, 32'h80000000, 5'd0);
    apply(5'd2, 32'hffffffff, 32'h80000000, 5'd0);
    // R2: same operands, unsigned forms never trap
    apply(5'd1, 32'h7fffffff, 32'h00000001, 5'd0);
    apply(5'd1, 32'h80000000, 32'hffffffff, 5'd0);
    apply(5'd3, 32'h80000000, 32'h00000001, 5'd0);
    apply(5'd3, 32'h00000000, 32'h80000000, 5'd0);
    // R4: bitwise functions
    apply(5'd4, 32'hf0f0ff00, 32'h3c3c0ff0, 5'd0);
    apply(5'd5, 32'hf0f0ff00, 32'h3c3c0ff0, 5'd0);
    apply(5'd6, 32'hf0f0ff00, 32'h3c3c0ff0, 5'd0);
    apply(5'd7, 32'hf0f0ff00, 32'h3c3c0ff0, 5'd0);
    // R5: constant shifts
    apply(5'd10, 32'h80000000, 32'h0, 5'd31);
    apply(5'd9,  32'h80000000, 32'h0, 5'd31);
    apply(5'd8,  32'h00000001, 32'h0, 5'd31);
    apply(5'd8,  32'hdeadbeef, 32'h0, 5'd0);
    apply(5'd10, 32'h40000000, 32'h0, 5'd4);
    // R6: variable shifts, upper amount bits ignored
    apply(5'd11, 32'h0000000f, 32'hffffffe4, 5'd9);
    apply(5'd12, 32'hf0000000, 32'hffffffe4, 5'd0);
    apply(5'd13, 32'hf0000000, 32'h7fffff3f, 5'd1);
    apply(5'd13, 32'h12345678, 32'hffffffe0, 5'd7);
    // R7 / R8: mixed signs
    apply(5'd14, 32'hffffffff, 32'h00000001, 5'd0);
    apply(5'd15, 32'hffffffff, 32'h00000001, 5'd0);
    apply(5'd14, 32'h80000000, 32'h7fffffff, 5'd0);
    apply(5'd15, 32'h80000000, 32'h7fffffff, 5'd0);
    apply(5'd14, 32'h00000005, 32'h00000005, 5'd0);
    // R9: upper immediate
    apply(5'd16, 32'h55555555, 32'habcd1234, 5'd3);
    // R10: unassigned codes
    apply(5'd17, 32'h7fffffff, 32'h00000001, 5'd3);
    apply(5'd31, 32'hffffffff, 32'hffffffff, 5'd31);
    // all requirements: mixed pseudo-random sweep over every code
    for (int n = 0; n < 4000; n++) begin
      logic [31:0] ra, rb;
      ra = $urandom;
      rb = $urandom;
      if (n % 4 == 0) ra = {ra[31], 31'h7fffffff ^ {26'd0, ra[4:0]}};
      apply(5'(n % 32), ra, rb, 5'($urandom));
    end
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

endmodule